// File: doc/BRIEF.md
# Clock Mode Selection Controller

This block decides the clocking mode of a small microcontroller from its configuration bits. From an oscillator enable, a request to take the FLL reference from the external oscillator, a request to run the bus straight from the oscillator, and the oscillator-ready flag, it chooses one of three modes. In engaged-internal mode the loop locks to the internal 32 kHz reference and the bus runs from the DCO. In engaged-external mode the loop locks to the divided-down oscillator and the bus still runs from the DCO. In bypassed-external mode the DCO is switched off and the bus runs from the oscillator.

The mode is registered and follows the inputs one clock later. The block also decodes the power-of-two divide ratios for the loop reference and for the bus. It holds a sticky flag that marks every change in the loop's lock status, and that flag can raise an interrupt. When the oscillator monitor reports a failure, the block falls back to the internal mode and sends out a single-cycle reset request.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, mode_code is 00, fll_ref_ext is 0, dco_en is 1, bus_src_osc is 0, and lock_flag, lock_irq and reset_req are 0.
- R2: With osc_en=1, osc_ready=1, ext_ref_req=1 and bus_byp_req=0, one clock later mode_code is 01, fll_ref_ext is 1, dco_en is 1 and bus_src_osc is 0.
- R3: With osc_en=1, osc_ready=1 and bus_byp_req=1, one clock later mode_code is 10, bus_src_osc is 1, dco_en is 0 and fll_ref_ext is 0.
- R4: When ext_ref_req and bus_byp_req are both 1 and the oscillator is valid, bypass mode (10) wins.
- R5: ext_ref_req and bus_byp_req have no effect while osc_en=0 or osc_ready=0. One clock later mode_code is 00 and dco_en is 1.
- R6: ref_div_ratio equals 2^ref_div_code, so a code from 0 to 7 gives a ratio from 1 to 128.
- R7: bus_div_ratio equals 2^bus_div_code.
- R8: One clock after fll_locked rises or falls, lock_flag is 1. It stays 1 until it is cleared.
- R9: A clock edge with lock_flag_clr=1 clears lock_flag. If a lock change arrives on the same edge, the set wins.
- R10: lock_irq is 1 exactly when lock_flag=1 and lock_irq_en=1.
- R11: While osc_mon_fail=1, one clock later the mode is 00 whatever the requests are. reset_req is 1 for exactly one clock after each rising edge of osc_mon_fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | External oscillator enable |
| ext_ref_req | input | 1 | Request the oscillator as FLL reference |
| bus_byp_req | input | 1 | Request the oscillator as bus source |
| ref_div_code | input | RDW | Reference divide exponent |
| bus_div_code | input | BDW | Bus divide exponent |
| osc_ready | input | 1 | Oscillator is stable |
| osc_mon_fail | input | 1 | Oscillator monitor reports loss of clock |
| fll_locked | input | 1 | FLL lock status |
| lock_irq_en | input | 1 | Lock-change interrupt enable |
| lock_flag_clr | input | 1 | Write-1 clear of the lock-change flag |
| fll_ref_ext | output | 1 | 1: FLL reference is the divided oscillator |
| ref_div_ratio | output | 2^RDW | Reference divide ratio |
| dco_en | output | 1 | DCO enable |
| bus_src_osc | output | 1 | 1: bus clock comes from the oscillator |
| bus_div_ratio | output | 2^BDW | Bus divide ratio |
| mode_code | output | 2 | 00 internal, 01 external engaged, 10 bypassed |
| lock_flag | output | 1 | Sticky lock-change flag |
| lock_irq | output | 1 | Lock-change interrupt request |
| reset_req | output | 1 | One-cycle reset request on oscillator failure |

## Verification
A corrupted mode register shows up one clock after the inputs change. It appears as a wrong mode_code together with dco_en, fll_ref_ext and bus_src_osc that disagree with the request pattern. A wrong priority shows up only when both requests are set at once. A faulty lock-edge detector shows up one clock after fll_locked toggles, as a missing or unwanted lock_flag. A faulty failure-edge register shows up as a reset_req that lasts for the whole failure instead of a single clock.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int RDW = 3,
  parameter int BDW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic               ext_ref_req,
  input  logic               bus_byp_req,
  input  logic [RDW-1:0]     ref_div_code,
  input  logic [BDW-1:0]     bus_div_code,
  input  logic               osc_ready,
  input  logic               osc_mon_fail,
  input  logic               fll_locked,
  input  logic               lock_irq_en,
  input  logic               lock_flag_clr,
  output logic               fll_ref_ext,
  output logic [(1<<RDW)-1:0] ref_div_ratio,
  output logic               dco_en,
  output logic               bus_src_osc,
  output logic [(1<<BDW)-1:0] bus_div_ratio,
  output logic [1:0]         mode_code,
  output logic               lock_flag,
  output logic               lock_irq,
  output logic               reset_req
);
  localparam logic [1:0] M_INT = 2'b00;
  localparam logic [1:0] M_EXT = 2'b01;
  localparam logic [1:0] M_BYP = 2'b10;

  logic [1:0] mode_q, mode_d;
  logic       lock_q, fail_q;
  logic       osc_ok;

  assign osc_ok = osc_en && osc_ready && !osc_mon_fail;

  always_comb begin
    mode_d = M_INT;
    if (osc_ok && bus_byp_req)      mode_d = M_BYP;
    else if (osc_ok && ext_ref_req) mode_d = M_EXT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_INT;
      lock_q    <= 1'b0;
      fail_q    <= 1'b0;
      lock_flag <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      lock_q    <= fll_locked;
      fail_q    <= osc_mon_fail;
      reset_req <= osc_mon_fail && !fail_q;
      if (fll_locked != lock_q) lock_flag <= 1'b1;
      else if (lock_flag_clr)   lock_flag <= 1'b0;
    end
  end

  assign mode_code     = mode_q;
  assign fll_ref_ext   = (mode_q == M_EXT);
  assign bus_src_osc   = (mode_q == M_BYP);
  assign dco_en        = (mode_q != M_BYP);
  assign ref_div_ratio = (1 << RDW)'(1) << ref_div_code;
  assign bus_div_ratio = (1 << BDW)'(1) << bus_div_code;
  assign lock_irq      = lock_flag && lock_irq_en;

  a_r3_bypass_stops_dco: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && osc_ready && bus_byp_req && !osc_mon_fail) |=> (!dco_en && bus_src_osc));

  a_r5_invalid_osc_internal: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_en && osc_ready) |=> (mode_code == 2'b00 && dco_en && !fll_ref_ext));

  a_r11_fail_forces_internal: assert property (@(posedge clk) disable iff (!rst_n)
    osc_mon_fail |=> (mode_code == 2'b00 && !bus_src_osc));

  a_r11_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r8_lock_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fll_locked != lock_q) |=> lock_flag);

  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flag_clr && fll_locked == lock_q) |=> !lock_flag);

  a_r2_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fll_ref_ext, bus_src_osc}));
endmodule

// File: tb/clk_mode_ctrl_tb_top.sv
module clk_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic osc_en = 0, ext_ref_req = 0, bus_byp_req = 0, osc_ready = 0;
  logic osc_mon_fail = 0, fll_locked = 0, lock_irq_en = 0, lock_flag_clr = 0;
  logic [2:0] ref_div_code = 0, bus_div_code = 0;
  logic fll_ref_ext, dco_en, bus_src_osc, lock_flag, lock_irq, reset_req;
  logic [7:0] ref_div_ratio, bus_div_ratio;
  logic [1:0] mode_code;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_mode(input string tag, input int m, input int ext, input int dco, input int osc);
    chk({tag, " mode"}, mode_code, m);
    chk({tag, " ref"}, fll_ref_ext, ext);
    chk({tag, " dco"}, dco_en, dco);
    chk({tag, " bus"}, bus_src_osc, osc);
  endtask

  task automatic t_reset();
    chk_mode("R1", 0, 0, 1, 1'b0);
    chk("R1 flag", lock_flag, 0);
    chk("R1 irq", lock_irq, 0);
    chk("R1 rreq", reset_req, 0);
  endtask

  task automatic t_modes();
    osc_en = 1; osc_ready = 1; ext_ref_req = 1; step();
    chk_mode("R2", 1, 1, 1, 0);
    ext_ref_req = 0; bus_byp_req = 1; step();
    chk_mode("R3", 2, 0, 0, 1);
    ext_ref_req = 1; step();
    chk_mode("R4", 2, 0, 0, 1);
    bus_byp_req = 0; ext_ref_req = 0; step();
    chk_mode("R2 back", 0, 0, 1, 0);
  endtask

  task automatic t_ignored();
    osc_en = 0; osc_ready = 1; ext_ref_req = 1; bus_byp_req = 1; step();
    chk_mode("R5 osc_en0", 0, 0, 1, 0);
    osc_en = 1; osc_ready = 0; step();
    chk_mode("R5 notready", 0, 0, 1, 0);
    ext_ref_req = 0; bus_byp_req = 0; osc_ready = 1; step();
  endtask

  task automatic t_div();
    for (int i = 0; i < 8; i++) begin
      ref_div_code = 3'(i); bus_div_code = 3'(7 - i); #1;
      chk("R6 refdiv", ref_div_ratio, 1 << i);
      chk("R7 busdiv", bus_div_ratio, 1 << (7 - i));
    end
  endtask

  task automatic t_lock();
    lock_irq_en = 0; fll_locked = 1; step();
    chk("R8 rise", lock_flag, 1);
    chk("R10 masked", lock_irq, 0);
    lock_irq_en = 1; #1;
    chk("R10 enabled", lock_irq, 1);
    step(); step();
    chk("R8 sticky", lock_flag, 1);
    lock_flag_clr = 1; step(); lock_flag_clr = 0;
    chk("R9 clear", lock_flag, 0);
    chk("R10 low", lock_irq, 0);
    fll_locked = 0; step();
    chk("R8 fall", lock_flag, 1);
    fll_locked = 1; lock_flag_clr = 1; step(); lock_flag_clr = 0;
    chk("R9 set wins", lock_flag, 1);
    lock_flag_clr = 1; step(); lock_flag_clr = 0;
    chk("R9 clear2", lock_flag, 0);
  endtask

  task automatic t_fail();
    bus_byp_req = 1; step();
    chk_mode("R11 pre", 2, 0, 0, 1);
    osc_mon_fail = 1; step();
    chk_mode("R11 forced", 0, 0, 1, 0);
    chk("R11 pulse", reset_req, 1);
    step();
    chk("R11 pulse end", reset_req, 0);
    chk("R11 held", mode_code, 0);
    osc_mon_fail = 0; step();
    chk("R11 recover", mode_code, 2);
    chk("R11 no req", reset_req, 0);
    bus_byp_req = 0;
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
      begin
        step(); step(); rst_n = 1; step();
        t_reset(); t_modes(); t_ignored(); t_div(); t_lock(); t_fail();
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule